// File: doc/BRIEF.md
# Four-Channel Prescaled Interval Timer

A bank of four independent 24-bit down-counters sitting behind a small register window. Software programs each channel through a load, a current-value, a control and a clear register. A single free-running prescaler, advanced by a base-tick enable input, is shared by all channels. Each channel picks its own rate from that prescaler: every tick, every 16th tick or every 256th tick.

When an armed channel's counter reaches zero, the channel disarms. If its enable bit is set, it also raises its own interrupt line. That line stays high until software acknowledges it by writing the channel's load, control or clear register. Periodic channels are restarted by the clear write. One-shot channels must be reloaded explicitly. A control word that selects both divide rates is illegal. Such a word is flagged on a per-channel error output, and the channel stops counting while the word is in place.

Top module: `quad_interval_timer`

## Requirements
- R1: Address bits [6:5] select the channel. Address bits [4:2] select the register inside the channel: 0 is load, 1 is value, 2 is control and 3 is clear. Reads of any other offset, including clear, return zero.
- R2: After reset, every channel's control register reads 0x40 (periodic set, enable clear), its load register reads 0xFFFFFF and its value reads 0. All irq and cfg_err bits are low.
- R3: A load write stores wdata masked to 24 bits into both the load register and the counter. It arms the channel and drops that channel's irq.
- R4: Control bit 7 is enable, bit 6 is periodic, bit 2 selects divide-by-16 and bit 3 selects divide-by-256. A control write stores wdata[7:0]. If bit 7 of the written word is set, it also copies the load register into the counter and arms the channel. Every control write drops that channel's irq.
- R5: A clear write always drops that channel's irq. It reloads the counter from the load register and arms the channel only when the periodic bit is set; in one-shot mode the counter is left unchanged.
- R6: An armed channel decrements by one on each of its rate strobes and saturates at zero. When the counter reaches zero, the channel disarms and sets its irq only if the enable bit is set. No further interrupt follows until the channel is re-armed.
- R7: With neither divide bit set, the channel counts on every tick. With bit 2 set, it counts once in every 16 consecutive ticks. With bit 3 set, it counts once in every 256 consecutive ticks.
- R8: When bits 2 and 3 are both set, cfg_err for that channel is high and the counter holds. The flag falls once a legal control word is written.
- R9: A value write overwrites the counter with the masked data. It changes neither the armed state nor the irq.
- R10: Registers, counters and interrupts of one channel are not affected by accesses to another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base count enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Byte address within the timer window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| irq | output | 4 | Per-channel pending interrupt |
| cfg_err | output | 4 | Per-channel illegal divide selection |

## Verification
The bench builds the timer with its default widths: a 24-bit counter and a 32-bit data bus. At these widths the masking of the top data byte and the all-ones reset load are visible at the ports. Small load values keep every expiry within a few ticks. Runs of 32 and 256 ticks contain exactly two and exactly one divided strobes, whatever the prescaler phase. This makes both divided rates checkable without knowing how many ticks have gone before.

// File: rtl/quad_interval_timer.sv
module quad_interval_timer #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [6:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [3:0]        irq,
  output logic [3:0]        cfg_err
);
  localparam int NCH   = 4;
  localparam int PRE_W = 8;
  localparam int EN_B  = 7;
  localparam int PER_B = 6;
  localparam int D16_B = 2;
  localparam int D256_B = 3;

  logic [PRE_W-1:0] pre;
  wire str16  = tick & (&pre[3:0]);
  wire str256 = tick & (&pre);
  wire [1:0] ch  = addr[6:5];
  wire [2:0] off = addr[4:2];
  wire unused_bits = &{1'b0, addr[1:0], wdata};

  always_ff @(posedge clk)
    if (!rst_n) pre <= '0;
    else if (tick) pre <= pre + 1'b1;

  logic [CNT_W-1:0] ld_a  [NCH];
  logic [CNT_W-1:0] cnt_a [NCH];
  logic [7:0]       ctl_a [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CNT_W-1:0] ld, cnt;
    logic [7:0] ctl;
    logic armed, pend, step;
    wire sel = wr_en && (ch == c);
    wire [CNT_W-1:0] wv = wdata[CNT_W-1:0];
    wire bad = ctl[D16_B] & ctl[D256_B];

    always_comb begin
      if (bad)              step = 1'b0;
      else if (ctl[D16_B])  step = str16;
      else if (ctl[D256_B]) step = str256;
      else                  step = tick;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ld    <= '1;
        cnt   <= '0;
        ctl   <= 8'h40;
        armed <= 1'b0;
        pend  <= 1'b0;
      end else if (sel && off == 3'd0) begin
        ld    <= wv;
        cnt   <= wv;
        armed <= 1'b1;
        pend  <= 1'b0;
      end else if (sel && off == 3'd1) begin
        cnt <= wv;
      end else if (sel && off == 3'd2) begin
        ctl  <= wdata[7:0];
        pend <= 1'b0;
        if (wdata[EN_B]) begin
          cnt   <= ld;
          armed <= 1'b1;
        end
      end else if (sel && off == 3'd3) begin
        pend <= 1'b0;
        if (ctl[PER_B]) begin
          cnt   <= ld;
          armed <= 1'b1;
        end
      end else if (armed && step) begin
        if (cnt > 1) cnt <= cnt - 1'b1;
        else begin
          cnt   <= '0;
          armed <= 1'b0;
          pend  <= ctl[EN_B];
        end
      end
    end

    assign ld_a[c]    = ld;
    assign cnt_a[c]   = cnt;
    assign ctl_a[c]   = ctl;
    assign irq[c]     = pend;
    assign cfg_err[c] = bad;
  end

  always_comb begin
    rdata = '0;
    case (off)
      3'd0: rdata[CNT_W-1:0] = ld_a[ch];
      3'd1: rdata[CNT_W-1:0] = cnt_a[ch];
      3'd2: rdata[7:0]       = ctl_a[ch];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/quad_interval_timer_chk.sv
module quad_interval_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [6:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [3:0]        irq,
  input logic [3:0]        cfg_err
);
  for (genvar c = 0; c < 4; c++) begin : g_chk
    wire hit = wr_en && addr[6:5] == c;
    wire w_ld  = hit && addr[4:2] == 3'd0;
    wire w_ctl = hit && addr[4:2] == 3'd2;
    wire w_clr = hit && addr[4:2] == 3'd3;

    assert_irq_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> $past(tick));
    assert_ack_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      w_ld |=> !irq[c]);
    assert_ack_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      w_ctl |=> !irq[c]);
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      w_clr |=> !irq[c]);
    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctl && wdata[2] && wdata[3]) |=> cfg_err[c]);
    assert_err_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctl && !(wdata[2] && wdata[3])) |=> !cfg_err[c]);
  end
endmodule

bind quad_interval_timer quad_interval_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .cfg_err(cfg_err)
);

// File: tb/quad_interval_timer_bench.sv
`timescale 1ns/1ps
module quad_interval_timer_bench;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0] irq, cfg_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_interval_timer u_quad_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .cfg_err(cfg_err));

  // {is_read, req, addr, data/expected}
  localparam int NV = 13;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 4'd3,  7'h00, 32'hFF12_3456},
    {1'b1, 4'd3,  7'h00, 32'h0012_3456},   // R3 masked load
    {1'b1, 4'd3,  7'h04, 32'h0012_3456},   // R3 counter copy
    {1'b0, 4'd9,  7'h24, 32'h0000_0ABC},
    {1'b1, 4'd9,  7'h24, 32'h0000_0ABC},   // R9 value overwrite
    {1'b1, 4'd10, 7'h20, 32'h00FF_FFFF},   // R10 load of ch1 untouched
    {1'b0, 4'd4,  7'h48, 32'h0000_0044},
    {1'b1, 4'd4,  7'h48, 32'h0000_0044},   // R4 control readback
    {1'b1, 4'd10, 7'h08, 32'h0000_0040},   // R10 ch0 control untouched
    {1'b1, 4'd1,  7'h7C, 32'h0000_0000},   // R1 unmapped offset
    {1'b0, 4'd5,  7'h6C, 32'h0000_0000},
    {1'b1, 4'd5,  7'h64, 32'h00FF_FFFF},   // R5 periodic reload
    {1'b1, 4'd1,  7'h10, 32'h0000_0000}    // R1 unmapped offset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    for (int c = 0; c < 4; c++) begin
      rd(7'(c*32 + 0), d); chk("R2 load", d, 32'hFFFFFF);
      rd(7'(c*32 + 4), d); chk("R2 value", d, 0);
      rd(7'(c*32 + 8), d); chk("R2 ctrl", d, 32'h40);
    end
    chk("R2 irq", {28'd0, irq}, 0);
    chk("R2 err", {28'd0, cfg_err}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][43]) begin
        rd(VEC[i][38:32], d);
        chk($sformatf("R%0d vec%0d", VEC[i][42:39], i), d, VEC[i][31:0]);
      end else wr(VEC[i][38:32], VEC[i][31:0]);
    end

    // R6 periodic expiry on ch0
    wr(7'h00, 3); wr(7'h08, 32'hC0);
    ticks(2); rd(7'h04, d); chk("R6 count", d, 1);
    chk("R6 no early irq", {31'd0, irq[0]}, 0);
    ticks(1); chk("R6 irq", {31'd0, irq[0]}, 1);
    ticks(2); rd(7'h04, d); chk("R6 saturate", d, 0);
    chk("R6 irq held", {31'd0, irq[0]}, 1);
    wr(7'h0C, 0); chk("R5 ack", {31'd0, irq[0]}, 0);
    rd(7'h04, d); chk("R5 periodic reload", d, 3);

    // one-shot
    wr(7'h08, 32'h80); rd(7'h04, d); chk("R4 enable reload", d, 3);
    ticks(3); chk("R6 one-shot irq", {31'd0, irq[0]}, 1);
    wr(7'h0C, 0); chk("R5 one-shot ack", {31'd0, irq[0]}, 0);
    rd(7'h04, d); chk("R5 no reload", d, 0);
    ticks(5); chk("R6 no rearm", {31'd0, irq[0]}, 0);

    // R3 load acknowledges
    wr(7'h00, 1); ticks(1); chk("R3 setup irq", {31'd0, irq[0]}, 1);
    wr(7'h00, 5); chk("R3 load ack", {31'd0, irq[0]}, 0);
    rd(7'h04, d); chk("R3 load value", d, 5);

    // disabled channel never interrupts
    wr(7'h48, 32'h40); wr(7'h40, 2); ticks(3);
    rd(7'h44, d); chk("R6 disabled count", d, 0);
    chk("R6 disabled irq", {31'd0, irq[2]}, 0);

    // R7 divided rates on ch1
    wr(7'h28, 32'hC4); wr(7'h20, 5); ticks(32);
    rd(7'h24, d); chk("R7 div16", d, 3);
    wr(7'h28, 32'hC8); ticks(256);
    rd(7'h24, d); chk("R7 div256", d, 4);

    // R8 illegal divide
    wr(7'h28, 32'h8C); chk("R8 err set", {31'd0, cfg_err[1]}, 1);
    ticks(40); rd(7'h24, d); chk("R8 hold", d, 5);
    wr(7'h28, 32'h84); chk("R8 err clear", {31'd0, cfg_err[1]}, 0);

    // R9 value write keeps disarmed, no ack
    wr(7'h08, 32'h80); ticks(5); chk("R9 setup irq", {31'd0, irq[0]}, 1);
    wr(7'h04, 3); ticks(4);
    rd(7'h04, d); chk("R9 stays disarmed", d, 3);
    chk("R9 irq kept", {31'd0, irq[0]}, 1);
    chk("R10 other irqs", {28'd0, irq}, 32'h1);

    finish_run();
  end
endmodule